// File: doc/BRIEF.md
# Warm Reset Handshake Sequencer

This block runs a hardware-sequenced warm reset. A software request starts the sequence. Before any warm reset output goes high, the sequencer sends a quiesce request to every agent that has its enable bit set and is not already in reset. There are five such agents: SDRAM self-refresh entry, clock idling in two clock-manager agents, a fabric handshake, and a stall of a trace AXI master. It then waits until each requested agent has acknowledged or its wait has timed out. After that it holds warm reset for a fixed number of cycles, releases it, and drops the requests.

The trace agent has two extra duties. A debug-reset request runs the same sequence using only the trace stall handshake, and drives a separate debug reset output. After a warm reset that ran while trace stalling was enabled, a pending flag keeps the trace master stalled. The flag stays set until software writes 1 to clear it.

A cold reset request wins over everything else. It aborts a sequence in progress, drops all requests, clears the trace pending flag and drives cold reset for the hold time.

Top module: `warm_rst_seq`

## Requirements
- R1: Agent bit positions in every agent vector are 0 SDRAM self-refresh, 1 fabric-manager clock idle, 2 scan-manager clock idle, 3 fabric, 4 trace stall. When a warm request is sampled in idle, `hs_req_o` rises for the targeted agents on that same edge. `warm_rst_o` is asserted only after every targeted agent is done. With no agent targeted, `warm_rst_o` is high after the second edge.
- R2: Only agents with `hs_en_i`=1 and `agent_in_rst_i`=0 receive a request. Every other agent is treated as done at once.
- R3: All targeted requests rise in the same cycle. `warm_rst_o` rises on the second edge after the edge that samples the last outstanding acknowledge.
- R4: If a targeted agent gives no acknowledge within TIMEOUT_CYC cycles, it counts as done and its `timeout_o` bit is set. Warm reset then rises TIMEOUT_CYC+2 edges after the request edge. The flags are cleared when the next sequence starts.
- R5: `warm_rst_o` stays high for exactly HOLD_CYC cycles. It falls on the same edge at which all handshake requests fall, and `busy_o` then returns to 0.
- R6: If a warm reset runs while `hs_en_i[4]` is 1, a trace pending flag is set on entry to the hold phase. The flag keeps `hs_req_o[4]` and `trace_pend_o` high after the sequence ends.
- R7: A one-cycle pulse on `trace_pend_clr_i` clears the pending flag. `trace_pend_o` and `hs_req_o[4]` go low on that edge.
- R8: A debug request in idle targets only the trace agent. After that handshake it drives `dbg_rst_o` for HOLD_CYC cycles. It never drives `warm_rst_o` and never sets the pending flag.
- R9: A cold request drives `cold_rst_o` from the next edge for HOLD_CYC cycles. It drops every request and clears the pending flag. It aborts any sequence, so `warm_rst_o` stays low, and the block then returns to idle.
- R10: A cold request sampled together with a warm or debug request wins, and no handshake request is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sw_warm_req_i | input | 1 | Software warm reset request pulse |
| sw_cold_req_i | input | 1 | Software cold reset request pulse |
| dbg_req_i | input | 1 | Debug reset request pulse |
| trace_pend_clr_i | input | 1 | Write-1 pulse clearing the trace pending flag |
| hs_en_i | input | N_AGENTS | Per-agent handshake enable |
| agent_in_rst_i | input | N_AGENTS | Per-agent already-in-reset status |
| hs_ack_i | input | N_AGENTS | Per-agent acknowledge |
| hs_req_o | output | N_AGENTS | Per-agent quiesce request |
| timeout_o | output | N_AGENTS | Per-agent sticky timeout flag |
| warm_rst_o | output | 1 | Warm reset output |
| dbg_rst_o | output | 1 | Debug reset output for trace logic |
| cold_rst_o | output | 1 | Cold reset output |
| trace_pend_o | output | 1 | Trace stall pending after warm reset |
| busy_o | output | 1 | Sequence or cold reset in progress |

## Verification
The assertions assume that request inputs are single-cycle pulses given while the block is idle, except for cold requests, which may come at any time. They also assume that an acknowledge is high only while its request is high. The bench drives requests one at a time at the falling edge, and only after `busy_o` has returned low. Its responder models derive each acknowledge from `hs_req_o` with a programmable delay, and a very large delay stands for an agent that never answers. Cold requests are injected on purpose in the middle of a handshake and in the same cycle as a warm request.

// File: rtl/warm_seq_pkg.sv
package warm_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HS   = 2'd1,
    ST_HOLD = 2'd2,
    ST_COLD = 2'd3
  } seq_state_e;
endpackage

// File: rtl/warm_seq_agent.sv
module warm_seq_agent #(
  parameter int TIMEOUT_CYC = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mask_i,
  input  logic clr_i,
  input  logic ack_i,
  output logic req_o,
  output logic done_o,
  output logic to_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] TO_LAST = CW'(TIMEOUT_CYC - 1);

  logic          req_q, active_q, done_q, to_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q    <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b1;
      to_q     <= 1'b0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      req_q    <= 1'b0;
      active_q <= 1'b0;
      done_q   <= 1'b1;
    end else if (start_i) begin
      req_q    <= mask_i;
      active_q <= mask_i;
      done_q   <= ~mask_i;
      to_q     <= 1'b0;
      cnt_q    <= '0;
    end else if (active_q && !done_q) begin
      if (ack_i) begin
        done_q <= 1'b1;
      end else if (cnt_q == TO_LAST) begin
        done_q <= 1'b1;
        to_q   <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign req_o  = req_q;
  assign done_o = done_q;
  assign to_o   = to_q;

  AST_REQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $past(start_i && mask_i)); // R2
  AST_TO_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_q && !done_q) |-> (cnt_q < CW'(TIMEOUT_CYC))); // R4
  AST_TO_NEEDS_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_q) |-> $past(req_q)); // R4
endmodule

// File: rtl/warm_seq_timer.sv
module warm_seq_timer #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic last_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] H_LAST = HW'(HOLD_CYC - 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (restart_i || !run_i)    cnt_q <= '0;
    else if (cnt_q != H_LAST)        cnt_q <= cnt_q + 1'b1;
    else                             cnt_q <= '0;
  end

  assign last_o = run_i && (cnt_q == H_LAST);

  AST_HOLD_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < HW'(HOLD_CYC)); // R5
endmodule

// File: rtl/warm_seq_ctrl.sv
module warm_seq_ctrl
  import warm_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       warm_req_i,
  input  logic       cold_req_i,
  input  logic       dbg_req_i,
  input  logic       all_done_i,
  input  logic       hold_last_i,
  input  logic       trace_en_i,
  input  logic       pend_clr_i,
  output seq_state_e state_o,
  output logic       dbg_mode_o,
  output logic       start_o,
  output logic       release_o,
  output logic       pend_o
);
  seq_state_e state_q, state_d;
  logic       dbg_q, pend_q;
  logic       enter_hold;

  assign start_o    = (state_q == ST_IDLE) && !cold_req_i && (warm_req_i || dbg_req_i);
  assign enter_hold = (state_q == ST_HS) && all_done_i && !cold_req_i;
  assign release_o  = cold_req_i || ((state_q == ST_HOLD) && hold_last_i);

  always_comb begin
    state_d = state_q;
    if (cold_req_i) begin
      state_d = ST_COLD;
    end else begin
      unique case (state_q)
        ST_IDLE: if (warm_req_i || dbg_req_i) state_d = ST_HS;
        ST_HS:   if (all_done_i)              state_d = ST_HOLD;
        ST_HOLD: if (hold_last_i)             state_d = ST_IDLE;
        ST_COLD: if (hold_last_i)             state_d = ST_IDLE;
        default:                              state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dbg_q   <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (start_o) dbg_q <= !warm_req_i;  // warm wins over debug
      if (cold_req_i)                           pend_q <= 1'b0;
      else if (enter_hold && !dbg_q && trace_en_i) pend_q <= 1'b1;
      else if (pend_clr_i)                      pend_q <= 1'b0;
    end
  end

  assign state_o    = state_q;
  assign dbg_mode_o = dbg_q;
  assign pend_o     = pend_q;

  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_q) && !$past(pend_clr_i) && !$past(cold_req_i)) |-> pend_q); // R6
  AST_DBG_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> !dbg_q); // R8
endmodule

// File: rtl/warm_rst_seq.sv
module warm_rst_seq
  import warm_seq_pkg::*;
#(
  parameter int N_AGENTS    = 5,
  parameter int TRACE_IDX   = 4,
  parameter int TIMEOUT_CYC = 1024,
  parameter int HOLD_CYC    = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sw_warm_req_i,
  input  logic                sw_cold_req_i,
  input  logic                dbg_req_i,
  input  logic                trace_pend_clr_i,
  input  logic [N_AGENTS-1:0] hs_en_i,
  input  logic [N_AGENTS-1:0] agent_in_rst_i,
  input  logic [N_AGENTS-1:0] hs_ack_i,
  output logic [N_AGENTS-1:0] hs_req_o,
  output logic [N_AGENTS-1:0] timeout_o,
  output logic                warm_rst_o,
  output logic                dbg_rst_o,
  output logic                cold_rst_o,
  output logic                trace_pend_o,
  output logic                busy_o
);
  localparam logic [N_AGENTS-1:0] TRACE_BIT =
    {{(N_AGENTS-1){1'b0}}, 1'b1} << TRACE_IDX;

  seq_state_e          state;
  logic                dbg_mode, start, release_all, pend, hold_last, all_done;
  logic [N_AGENTS-1:0] mask, agent_req, agent_done;

  assign mask     = (hs_en_i & ~agent_in_rst_i) & (sw_warm_req_i ? {N_AGENTS{1'b1}} : TRACE_BIT);
  assign all_done = &agent_done;

  warm_seq_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .warm_req_i  (sw_warm_req_i),
    .cold_req_i  (sw_cold_req_i),
    .dbg_req_i   (dbg_req_i),
    .all_done_i  (all_done),
    .hold_last_i (hold_last),
    .trace_en_i  (hs_en_i[TRACE_IDX]),
    .pend_clr_i  (trace_pend_clr_i),
    .state_o     (state),
    .dbg_mode_o  (dbg_mode),
    .start_o     (start),
    .release_o   (release_all),
    .pend_o      (pend)
  );

  warm_seq_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     ((state == ST_HOLD) || (state == ST_COLD)),
    .restart_i (sw_cold_req_i),
    .last_o    (hold_last)
  );

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    warm_seq_agent #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_agent (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .mask_i  (mask[g]),
      .clr_i   (release_all),
      .ack_i   (hs_ack_i[g]),
      .req_o   (agent_req[g]),
      .done_o  (agent_done[g]),
      .to_o    (timeout_o[g])
    );
    if (g == TRACE_IDX) begin : g_trace
      assign hs_req_o[g] = agent_req[g] | pend;
    end else begin : g_plain
      assign hs_req_o[g] = agent_req[g];
    end
  end

  assign warm_rst_o   = (state == ST_HOLD) && !dbg_mode;
  assign dbg_rst_o    = (state == ST_HOLD) && dbg_mode;
  assign cold_rst_o   = (state == ST_COLD);
  assign trace_pend_o = pend;
  assign busy_o       = (state != ST_IDLE);

  AST_WARM_AFTER_HS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(warm_rst_o) |-> $past(busy_o) && !$past(warm_rst_o)); // R1
  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_IDLE) |-> (agent_req == '0)); // R5
  AST_COLD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cold_rst_o |-> !warm_rst_o && !dbg_rst_o && (agent_req == '0)); // R9
  AST_COLD_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_cold_req_i |=> cold_rst_o && !trace_pend_o); // R10
  AST_ONE_RST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({warm_rst_o, dbg_rst_o, cold_rst_o}) <= 1); // R8
endmodule

// File: tb/warm_rst_seq_tb_top.sv
module warm_rst_seq_tb_top;
  localparam int N  = 5;
  localparam int TO = 20;
  localparam int HC = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         warm = 1'b0, cold = 1'b0, dbg = 1'b0, pclr = 1'b0;
  logic [N-1:0] en = '0, in_rst = '0, ack;
  logic [N-1:0] req, tout;
  logic         warm_rst, dbg_rst, cold_rst, pend, busy;
  int           dly [N];
  int           rcnt [N];
  int           checks = 0, errors = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  warm_rst_seq #(.N_AGENTS(N), .TRACE_IDX(4), .TIMEOUT_CYC(TO), .HOLD_CYC(HC)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sw_warm_req_i(warm), .sw_cold_req_i(cold),
    .dbg_req_i(dbg), .trace_pend_clr_i(pclr), .hs_en_i(en), .agent_in_rst_i(in_rst),
    .hs_ack_i(ack), .hs_req_o(req), .timeout_o(tout), .warm_rst_o(warm_rst),
    .dbg_rst_o(dbg_rst), .cold_rst_o(cold_rst), .trace_pend_o(pend), .busy_o(busy)
  );

  // responders: ack once request has been high for dly cycles
  always @(posedge clk) begin
    for (int i = 0; i < N; i++) rcnt[i] <= req[i] ? rcnt[i] + 1 : 0;
  end
  always_comb begin
    for (int i = 0; i < N; i++) ack[i] = req[i] && (rcnt[i] >= dly[i]);
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic set_dly(input int d0, input int d1, input int d2, input int d3, input int d4);
    dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3; dly[4] = d4;
  endtask

  // run one warm sequence; returns after outputs released
  task automatic run_warm(input string r, input int exp_req, input int exp_lat,
                          input int exp_to, input int exp_after);
    int lat, h;
    @(negedge clk) warm = 1'b1;
    @(negedge clk) warm = 1'b0;
    lat = 1;
    chk(req == N'(exp_req), {r, " req mask"}, int'(req), exp_req);
    while (!warm_rst && lat < 200) begin @(negedge clk); lat++; end
    chk(lat == exp_lat, {r, " warm latency"}, lat, exp_lat);
    h = 0;
    while (warm_rst && h < 200) begin @(negedge clk); h++; end
    chk(h == HC, "R5 hold length", h, HC);
    chk(req == N'(exp_after), "R5 req after release", int'(req), exp_after);
    chk(busy == 1'b0, "R5 busy after release", int'(busy), 0);
    chk(tout == N'(exp_to), "R4 timeout flags", int'(tout), exp_to);
  endtask

  task automatic t_reset;
    chk({req, tout, warm_rst, dbg_rst, cold_rst, pend, busy} == '0, "R1 reset state",
        int'({req, tout}), 0);
  endtask

  task automatic t_none;
    en = '0; in_rst = '0; set_dly(0, 0, 0, 0, 0);
    run_warm("R1", 0, 2, 0, 0);
  endtask

  task automatic t_acks;
    en = 5'b01111; in_rst = '0; set_dly(0, 3, 5, 1, 0);
    run_warm("R3", 5'b01111, 8, 0, 0);
  endtask

  task automatic t_skip;
    en = 5'b01111; in_rst = 5'b00101; set_dly(9, 3, 9, 1, 0);
    run_warm("R2", 5'b01010, 6, 0, 0);
    in_rst = '0;
  endtask

  task automatic t_timeout;
    en = 5'b00100; set_dly(0, 0, 1000, 0, 0);
    run_warm("R4", 5'b00100, TO + 2, 5'b00100, 0);
    en = '0;
    run_warm("R4 clear", 0, 2, 0, 0);
  endtask

  task automatic t_trace;
    en = 5'b10000; set_dly(0, 0, 0, 0, 2);
    run_warm("R6", 5'b10000, 5, 0, 5'b10000);
    chk(pend == 1'b1, "R6 pending set", int'(pend), 1);
    repeat (5) @(negedge clk);
    chk(req[4] == 1'b1 && pend, "R6 stall held", int'(req[4]), 1);
    pclr = 1'b1;
    @(negedge clk) pclr = 1'b0;
    chk(pend == 1'b0, "R7 pending cleared", int'(pend), 0);
    chk(req == '0, "R7 stall released", int'(req), 0);
  endtask

  task automatic t_debug;
    int lat, h;
    bit warm_seen = 0;
    en = 5'b10011; set_dly(0, 0, 0, 0, 0);
    @(negedge clk) dbg = 1'b1;
    @(negedge clk) dbg = 1'b0;
    lat = 1;
    chk(req == 5'b10000, "R8 only trace request", int'(req), 16);
    while (!dbg_rst && lat < 200) begin warm_seen |= warm_rst; @(negedge clk); lat++; end
    chk(lat == 3, "R8 debug latency", lat, 3);
    h = 0;
    while (dbg_rst && h < 200) begin warm_seen |= warm_rst; @(negedge clk); h++; end
    chk(h == HC, "R8 debug hold", h, HC);
    chk(!warm_seen, "R8 no warm reset", int'(warm_seen), 0);
    chk(pend == 1'b0 && req == '0, "R8 no pending", int'(pend), 0);
  endtask

  task automatic t_cold_abort;
    int h;
    bit warm_seen = 0;
    en = 5'b10000; set_dly(0, 0, 0, 0, 0);
    run_warm("R6 setup", 5'b10000, 3, 0, 5'b10000);
    en = 5'b00001; set_dly(1000, 0, 0, 0, 0);
    pclr = 1'b1;
    @(negedge clk) pclr = 1'b0;
    @(negedge clk) warm = 1'b1;
    @(negedge clk) warm = 1'b0;
    repeat (3) @(negedge clk);
    en = 5'b10000;
    run_warm_pend_then_cold();
    cold = 1'b1;
    @(negedge clk) cold = 1'b0;
    chk(cold_rst == 1'b1, "R9 cold asserted", int'(cold_rst), 1);
    chk(req == '0, "R9 requests dropped", int'(req), 0);
    chk(pend == 1'b0, "R9 pending cleared", int'(pend), 1'b0);
    h = 0;
    while (cold_rst && h < 200) begin warm_seen |= warm_rst; @(negedge clk); h++; end
    chk(h == HC, "R9 cold length", h, HC);
    chk(!warm_seen && !busy, "R9 aborted to idle", int'(busy), 0);
  endtask

  // placeholder-free helper: ensures block is mid-handshake with request up
  task automatic run_warm_pend_then_cold;
    chk(busy && req[0] && !warm_rst, "R9 mid handshake", int'(req), 1);
  endtask

  task automatic t_cold_prio;
    en = 5'b11111; set_dly(0, 0, 0, 0, 0);
    @(negedge clk) begin warm = 1'b1; cold = 1'b1; end
    @(negedge clk) begin warm = 1'b0; cold = 1'b0; end
    chk(cold_rst && !warm_rst, "R10 cold wins", int'(cold_rst), 1);
    chk(req == '0, "R10 no requests", int'(req), 0);
    while (busy) @(negedge clk);
    chk(warm_rst == 1'b0, "R10 idle after", int'(warm_rst), 0);
  endtask

  initial begin
    set_dly(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_none();
    t_acks();
    t_skip();
    t_timeout();
    t_trace();
    t_debug();
    t_cold_abort();
    t_cold_prio();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule